// File: doc/BRIEF.md
# Decoded Micro-op Line Cache

This block keeps micro-ops that a decoder has already produced, so that a hot stretch of code can be replayed without decoding it again. Every line belongs to one aligned 32-byte window of instruction bytes. A line holds from zero to six fixed-width micro-op payloads and the number of them that are valid. The cache is organised as 32 sets of 8 ways, which is 1536 micro-op slots in total.

A front end presents a window address on the lookup port. One cycle later the block reports hit or miss. On a hit it also returns the stored payloads and their count, so up to six micro-ops can go to the downstream queue per cycle. After a miss, the decoder writes its result through the fill port. A window that decodes to more than six micro-ops is refused, so it is never resident and always misses. Replacement within a set is least-recently-used. A flush input empties the whole cache in one cycle. Three counters track lookup hits, lookup misses and refused fills.

Top module: `uop_line_cache`

## Requirements
- R1: After synchronous reset, `rsp_valid_o` and `rsp_hit_o` are 0, all three counters are 0, and every window misses.
- R2: A lookup presented in cycle t gives `rsp_valid_o`=1 in cycle t+1. A cycle with no lookup gives `rsp_valid_o`=0 and `rsp_hit_o`=0.
- R3: The set is address bits [9:5], the tag is bits [31:10], and bits [4:0] are ignored. On a hit, `rsp_count_o` is the stored count and micro-op k sits at `rsp_uops_o[k*16 +: 16]`. On a miss, `rsp_count_o` is 0.
- R4: A fill with a count above 6 is not stored. If that window is resident, its line is removed. `reject_cnt_o` increments by one. A count of exactly 6 is stored.
- R5: A fill to a window that is already resident rewrites that line in its current way. No second copy is ever allocated.
- R6: A fill to a full set evicts the least-recently-used way. A hit and a stored fill each make their line the most recent.
- R7: A flush invalidates every line in one cycle. A lookup in the flush cycle misses, and a fill in the flush cycle is dropped without being counted.
- R8: Each lookup increments exactly one counter: `hit_cnt_o` on a hit, or `miss_cnt_o` on a miss.
- R9: A lookup in the same cycle as a fill sees the contents that were there before the fill.
- R10: When a fill is stored in the same cycle as a lookup hit, only the fill updates recency. The line that hit keeps its age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate all lines |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Lookup window address |
| fl_valid_i | input | 1 | Fill request |
| fl_addr_i | input | 32 | Fill window address |
| fl_count_i | input | 4 | Decoded micro-op count of the window |
| fl_uops_i | input | 96 | Six 16-bit micro-op payloads |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_count_o | output | 3 | Valid micro-ops in the response |
| rsp_uops_o | output | 96 | Returned micro-op payloads |
| hit_cnt_o | output | 16 | Lookup hit count |
| miss_cnt_o | output | 16 | Lookup miss count |
| reject_cnt_o | output | 16 | Refused fill count |

## Verification
The directed patterns each separate one pair of behaviours:
- Offset-only address changes against tag changes show whether the index and tag are cut at the right bits.
- Counts of 6 and 7 sit on either side of the refusal threshold.
- A refill followed by seven more fills to the same set shows whether a second way was allocated.
- A touched-then-fill sequence shows true LRU order as opposed to plain fill order.
- A hit that lands in the same cycle as a fill to another set shows whether that hit was allowed to change recency.

A random phase then mixes lookups, fills of every count and occasional flushes over a few crowded sets. A queue-per-set recency model checks the responses and counters of every cycle.

// File: rtl/uc_pkg.sv
package uc_pkg;
  // classification of the fill port each cycle
  typedef enum logic [1:0] {
    FK_IDLE   = 2'd0,
    FK_STORE  = 2'd1,
    FK_REFUSE = 2'd2
  } fill_kind_e;
endpackage

// File: rtl/uc_tag_store.sv
module uc_tag_store #(
  parameter int SETS  = 32,
  parameter int WAYS  = 8,
  parameter int TAG_W = 22,
  localparam int SET_LG = $clog2(SETS),
  localparam int WAY_LG = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [SET_LG-1:0] a_set,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [SET_LG-1:0] b_set,
  input  logic [TAG_W-1:0]  b_tag,
  input  logic              wr_en,
  input  logic [SET_LG-1:0] wr_set,
  input  logic [WAY_LG-1:0] wr_way,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              drop_en,
  input  logic [SET_LG-1:0] drop_set,
  input  logic [WAY_LG-1:0] drop_way,
  output logic [WAYS-1:0]   a_hit,
  output logic [WAYS-1:0]   b_hit,
  output logic [WAYS-1:0]   b_vld
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign a_hit[w] = vld_q[a_set][w] && (tag_q[a_set][w] == a_tag);
    assign b_hit[w] = vld_q[b_set][w] && (tag_q[b_set][w] == b_tag);
    assign b_vld[w] = vld_q[b_set][w];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (wr_en) begin
        vld_q[wr_set][wr_way] <= 1'b1;
        tag_q[wr_set][wr_way] <= wr_tag;
      end
      if (drop_en) vld_q[drop_set][drop_way] <= 1'b0;
    end
  end

  // a window never occupies two ways of its set
  assert_single_copy_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(a_hit) && $onehot0(b_hit));
endmodule

// File: rtl/uc_lru.sv
module uc_lru #(
  parameter int SETS = 32,
  parameter int WAYS = 8,
  localparam int SET_LG = $clog2(SETS),
  localparam int WAY_LG = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              touch_en,
  input  logic [SET_LG-1:0] touch_set,
  input  logic [WAY_LG-1:0] touch_way,
  input  logic [SET_LG-1:0] q_set,
  output logic [WAY_LG-1:0] victim
);
  localparam logic [WAY_LG-1:0] OLDEST = WAY_LG'(WAYS - 1);

  logic [WAY_LG-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]   oldest_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign oldest_vec[w] = (age_q[q_set][w] == OLDEST);
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (oldest_vec[w]) victim = WAY_LG'(w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_LG'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_LG'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  // ages stay a permutation: exactly one oldest way per set
  assert_one_oldest_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/uc_line_ram.sv
module uc_line_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 99,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // read-first single-clock RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/uop_line_cache.sv
module uop_line_cache #(
  parameter int ADDR_W = 32,
  parameter int WIN_LG = 5,
  parameter int SETS   = 32,
  parameter int WAYS   = 8,
  parameter int UOPS   = 6,
  parameter int UOP_W  = 16,
  parameter int FCNT_W = 4,
  parameter int STAT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush_i,
  input  logic                    lk_valid_i,
  input  logic [ADDR_W-1:0]       lk_addr_i,
  input  logic                    fl_valid_i,
  input  logic [ADDR_W-1:0]       fl_addr_i,
  input  logic [FCNT_W-1:0]       fl_count_i,
  input  logic [UOPS*UOP_W-1:0]   fl_uops_i,
  output logic                    rsp_valid_o,
  output logic                    rsp_hit_o,
  output logic [$clog2(UOPS+1)-1:0] rsp_count_o,
  output logic [UOPS*UOP_W-1:0]   rsp_uops_o,
  output logic [STAT_W-1:0]       hit_cnt_o,
  output logic [STAT_W-1:0]       miss_cnt_o,
  output logic [STAT_W-1:0]       reject_cnt_o
);
  import uc_pkg::*;

  localparam int SET_LG = $clog2(SETS);
  localparam int WAY_LG = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - WIN_LG - SET_LG;
  localparam int UCNT_W = $clog2(UOPS + 1);
  localparam int PL_W   = UOPS * UOP_W;
  localparam int LINES  = SETS * WAYS;
  localparam int LN_LG  = $clog2(LINES);
  localparam logic [FCNT_W-1:0] MAX_FILL = FCNT_W'(UOPS);

  logic [SET_LG-1:0] lk_set, fl_set;
  logic [TAG_W-1:0]  lk_tag, fl_tag;
  logic [WAYS-1:0]   a_hit, b_hit, b_vld;
  logic [WAY_LG-1:0] lk_way, fl_hit_way, free_way, victim, fl_way;
  logic              free_any, lk_hit, store_en, drop_en;
  fill_kind_e        fkind;
  logic [UCNT_W+PL_W-1:0] ram_q;

  assign lk_set = lk_addr_i[WIN_LG +: SET_LG];
  assign lk_tag = lk_addr_i[ADDR_W-1 -: TAG_W];
  assign fl_set = fl_addr_i[WIN_LG +: SET_LG];
  assign fl_tag = fl_addr_i[ADDR_W-1 -: TAG_W];

  always_comb begin
    lk_way = '0;
    fl_hit_way = '0;
    free_way = '0;
    free_any = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (a_hit[w]) lk_way = WAY_LG'(w);
      if (b_hit[w]) fl_hit_way = WAY_LG'(w);
      if (!b_vld[w]) begin
        free_way = WAY_LG'(w);
        free_any = 1'b1;
      end
    end
  end

  always_comb begin
    if (!fl_valid_i || flush_i)      fkind = FK_IDLE;
    else if (fl_count_i > MAX_FILL)  fkind = FK_REFUSE;
    else                             fkind = FK_STORE;
  end

  assign lk_hit   = lk_valid_i && !flush_i && (|a_hit);
  assign store_en = (fkind == FK_STORE);
  assign drop_en  = (fkind == FK_REFUSE) && (|b_hit);
  assign fl_way   = (|b_hit) ? fl_hit_way : (free_any ? free_way : victim);

  uc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst(rst), .flush(flush_i),
    .a_set(lk_set), .a_tag(lk_tag), .b_set(fl_set), .b_tag(fl_tag),
    .wr_en(store_en), .wr_set(fl_set), .wr_way(fl_way), .wr_tag(fl_tag),
    .drop_en(drop_en), .drop_set(fl_set), .drop_way(fl_hit_way),
    .a_hit(a_hit), .b_hit(b_hit), .b_vld(b_vld)
  );

  uc_lru #(.SETS(SETS), .WAYS(WAYS)) lru_i (
    .clk(clk), .rst(rst),
    .touch_en(store_en || lk_hit),
    .touch_set(store_en ? fl_set : lk_set),
    .touch_way(store_en ? fl_way : lk_way),
    .q_set(fl_set), .victim(victim)
  );

  uc_line_ram #(.DEPTH(LINES), .WIDTH(UCNT_W + PL_W)) ram_i (
    .clk(clk), .we(store_en),
    .waddr(LN_LG'({fl_set, fl_way})),
    .wdata({UCNT_W'(fl_count_i), fl_uops_i}),
    .raddr(LN_LG'({lk_set, lk_way})),
    .rdata(ram_q)
  );

  logic rsp_valid_q, rsp_hit_q;
  logic [STAT_W-1:0] hit_q, miss_q, rej_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      hit_q       <= '0;
      miss_q      <= '0;
      rej_q       <= '0;
    end else begin
      rsp_valid_q <= lk_valid_i;
      rsp_hit_q   <= lk_hit;
      if (lk_hit) hit_q <= hit_q + 1'b1;
      if (lk_valid_i && !lk_hit) miss_q <= miss_q + 1'b1;
      if (fkind == FK_REFUSE) rej_q <= rej_q + 1'b1;
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_hit_o    = rsp_hit_q;
  assign rsp_count_o  = rsp_hit_q ? ram_q[PL_W +: UCNT_W] : '0;
  assign rsp_uops_o   = ram_q[PL_W-1:0];
  assign hit_cnt_o    = hit_q;
  assign miss_cnt_o   = miss_q;
  assign reject_cnt_o = rej_q;

  assert_rsp_timing_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid_i |=> rsp_valid_o);
  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid_i |=> (!rsp_valid_o && !rsp_hit_o));
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_hit_o |-> (rsp_count_o <= UCNT_W'(UOPS)));
  assert_refuse_count_R4: assert property (@(posedge clk) disable iff (rst)
    (fl_valid_i && !flush_i && fl_count_i > MAX_FILL)
      |=> (reject_cnt_o == STAT_W'($past(reject_cnt_o) + 1'b1)));
  assert_flush_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (flush_i && lk_valid_i) |=> !rsp_hit_o);
  assert_after_flush_R7: assert property (@(posedge clk) disable iff (rst)
    (flush_i ##1 (lk_valid_i && !fl_valid_i && !flush_i)) |=> !rsp_hit_o);
  assert_one_tally_R8: assert property (@(posedge clk) disable iff (rst)
    lk_valid_i |=> (STAT_W'(hit_cnt_o + miss_cnt_o)
                    == STAT_W'($past(hit_cnt_o) + $past(miss_cnt_o) + 1'b1)));
endmodule

// File: tb/uop_line_cache_tb.sv
module uop_line_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, SETS = 32, WAYS = 8, UOPS = 6, UW = 16;
  localparam int TAG_W = 22, PL_W = UOPS * UW;

  logic clk = 1'b0, rst = 1'b1;
  logic flush = 0, lkv = 0, flv = 0;
  logic [AW-1:0] lka = '0, fla = '0;
  logic [3:0] flc = '0;
  logic [PL_W-1:0] flp = '0;
  logic rsp_valid, rsp_hit;
  logic [2:0] rsp_count;
  logic [PL_W-1:0] rsp_uops;
  logic [15:0] hit_cnt, miss_cnt, rej_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  uop_line_cache dut_i (
    .clk(clk), .rst(rst), .flush_i(flush),
    .lk_valid_i(lkv), .lk_addr_i(lka),
    .fl_valid_i(flv), .fl_addr_i(fla), .fl_count_i(flc), .fl_uops_i(flp),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_count_o(rsp_count),
    .rsp_uops_o(rsp_uops), .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt),
    .reject_cnt_o(rej_cnt)
  );

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [2:0]       cnt;
    logic [PL_W-1:0]  pl;
  } ent_t;

  ent_t q [SETS][$];
  int vecs = 0, bad = 0;
  int m_hit = 0, m_miss = 0, m_rej = 0;

  function automatic logic [AW-1:0] mk(int s, int t, int off);
    return AW'((t << 10) | ((s & 31) << 5) | (off & 31));
  endfunction

  function automatic logic [PL_W-1:0] mkpl(int seed);
    logic [PL_W-1:0] p;
    for (int k = 0; k < UOPS; k++) p[k*UW +: UW] = UW'(seed * 97 + k * 13 + 5);
    return p;
  endfunction

  function automatic int find(int s, logic [TAG_W-1:0] t);
    for (int i = 0; i < q[s].size(); i++) if (q[s][i].tag == t) return i;
    return -1;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: apply inputs, update model, compare everything
  task automatic tick(logic f, logic lv, logic [AW-1:0] la,
                      logic fv, logic [AW-1:0] fa, logic [3:0] fc, logic [PL_W-1:0] fp);
    int ls, fs, hi, fi;
    logic [TAG_W-1:0] lt, ft;
    logic e_hit, stored;
    ent_t e;
    flush = f; lkv = lv; lka = la; flv = fv; fla = fa; flc = fc; flp = fp;
    ls = int'(la[9:5]); lt = la[31:10];
    fs = int'(fa[9:5]); ft = fa[31:10];
    e_hit = 0; hi = -1; stored = 0; e = '0;
    if (lv && !f) begin
      hi = find(ls, lt);
      if (hi >= 0) begin e_hit = 1; e = q[ls][hi]; end
    end
    if (lv) begin if (e_hit) m_hit++; else m_miss++; end
    if (f) begin
      for (int s = 0; s < SETS; s++) q[s].delete();
    end else if (fv) begin
      fi = find(fs, ft);
      if (fc > 4'd6) begin
        m_rej++;
        if (fi >= 0) q[fs].delete(fi);
      end else begin
        stored = 1;
        if (fi >= 0) q[fs].delete(fi);
        else if (q[fs].size() == WAYS) void'(q[fs].pop_back());
        q[fs].push_front('{tag: ft, cnt: fc[2:0], pl: fp});
      end
    end
    if (e_hit && !stored) begin
      fi = find(ls, lt);
      if (fi >= 0) begin
        ent_t m = q[ls][fi];
        q[ls].delete(fi);
        q[ls].push_front(m);
      end
    end
    @(posedge clk);
    #1;
    check("R2 rsp_valid", 128'(rsp_valid), 128'(lv));
    check("R3 R6 rsp_hit vs model", 128'(rsp_hit), 128'(e_hit));
    check("R3 rsp_count vs model", 128'(rsp_count), 128'(e_hit ? e.cnt : 3'd0));
    if (e_hit) check("R3 rsp_uops vs model", 128'(rsp_uops), 128'(e.pl));
    check("R8 counters vs model", {80'd0, hit_cnt, miss_cnt, rej_cnt},
          {80'd0, 16'(m_hit), 16'(m_miss), 16'(m_rej)});
    flush = 0; lkv = 0; flv = 0;
  endtask

  task automatic idle();
    tick(0, 0, '0, 0, '0, 4'd0, '0);
  endtask
  task automatic look(logic [AW-1:0] a);
    tick(0, 1, a, 0, '0, 4'd0, '0);
  endtask
  task automatic fill(logic [AW-1:0] a, int c, int seed);
    tick(0, 0, '0, 1, a, 4'(c), mkpl(seed));
  endtask
  task automatic expect_hit(string req, logic h, int c, int seed);
    check(req, 128'(rsp_hit), 128'(h));
    if (h) begin
      check(req, 128'(rsp_count), 128'(c));
      check(req, 128'(rsp_uops), 128'(mkpl(seed)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    check("R1 rsp after reset", {rsp_valid, rsp_hit}, 2'b00);
    check("R1 counters after reset", {hit_cnt, miss_cnt, rej_cnt}, 48'd0);
    look(mk(3, 1, 0));
    expect_hit("R1 empty cache miss", 0, 0, 0);

    // R3 fields and offset bits
    fill(mk(3, 1, 0), 4, 11);
    look(mk(3, 1, 31));
    expect_hit("R3 hit with offset bits set", 1, 4, 11);
    look(mk(3, 2, 0));
    expect_hit("R3 other tag misses", 0, 0, 0);
    look(mk(4, 1, 0));
    expect_hit("R3 other set misses", 0, 0, 0);

    // R9 lookup concurrent with fill sees old state
    tick(0, 1, mk(5, 9, 0), 1, mk(5, 9, 0), 4'd2, mkpl(21));
    expect_hit("R9 same-cycle fill not visible", 0, 0, 0);
    look(mk(5, 9, 4));
    expect_hit("R9 visible next cycle", 1, 2, 21);

    // R4 refusal boundary
    fill(mk(3, 1, 0), 7, 12);
    check("R4 reject counter", 128'(rej_cnt), 128'd1);
    look(mk(3, 1, 0));
    expect_hit("R4 refused window misses", 0, 0, 0);
    fill(mk(3, 1, 0), 6, 13);
    look(mk(3, 1, 0));
    expect_hit("R4 six micro-ops stored", 1, 6, 13);
    check("R4 six not counted", 128'(rej_cnt), 128'd1);

    // R5 refill in place
    fill(mk(7, 100, 0), 3, 30);
    fill(mk(7, 100, 0), 5, 31);
    for (int i = 1; i < 8; i++) fill(mk(7, 100 + i, 0), 1, 30 + 10 * i);
    look(mk(7, 100, 0));
    expect_hit("R5 refilled line updated", 1, 5, 31);
    for (int i = 1; i < 8; i++) begin
      look(mk(7, 100 + i, 0));
      expect_hit("R5 no duplicate way", 1, 1, 30 + 10 * i);
    end

    // R6 LRU honours hits
    for (int i = 0; i < 8; i++) fill(mk(9, 200 + i, 0), 2, 200 + i);
    look(mk(9, 200, 0));
    expect_hit("R6 touch oldest", 1, 2, 200);
    fill(mk(9, 208, 0), 2, 208);
    look(mk(9, 201, 0));
    expect_hit("R6 LRU way evicted", 0, 0, 0);
    look(mk(9, 200, 0));
    expect_hit("R6 touched line kept", 1, 2, 200);

    // R10 hit during a stored fill leaves recency alone
    for (int i = 0; i < 8; i++) fill(mk(11, 300 + i, 0), 3, 300 + i);
    tick(0, 1, mk(11, 300, 0), 1, mk(12, 5, 0), 4'd1, mkpl(77));
    expect_hit("R10 hit during fill", 1, 3, 300);
    fill(mk(11, 308, 0), 3, 308);
    look(mk(11, 300, 0));
    expect_hit("R10 hit did not refresh", 0, 0, 0);
    look(mk(11, 301, 0));
    expect_hit("R10 next oldest kept", 1, 3, 301);

    // R7 flush
    tick(1, 1, mk(3, 1, 0), 1, mk(20, 1, 0), 4'd9, mkpl(5));
    expect_hit("R7 flush-cycle lookup misses", 0, 0, 0);
    check("R7 flush-cycle fill not counted", 128'(rej_cnt), 128'd1);
    look(mk(3, 1, 0));
    expect_hit("R7 line gone after flush", 0, 0, 0);
    look(mk(5, 9, 0));
    expect_hit("R7 other line gone", 0, 0, 0);
    check("R8 hit tally", 128'(hit_cnt), 128'(m_hit));

    // random mix over a few crowded sets
    for (int n = 0; n < 4000; n++) begin
      int s1 = $urandom_range(0, 2), s2 = $urandom_range(0, 2);
      int t1 = $urandom_range(0, 11), t2 = $urandom_range(0, 11);
      tick(($urandom_range(0, 199) == 0), $urandom_range(0, 1) == 1,
           mk(s1, t1, $urandom_range(0, 31)),
           $urandom_range(0, 2) == 0, mk(s2, t2, $urandom_range(0, 31)),
           4'($urandom_range(0, 9)), mkpl($urandom_range(0, 999)));
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule